// File: doc/BRIEF.md
# Serial I/Q Frame Slot Capture

This block sits behind a digital down-converter that sends its output as one serial stream, one bit per clock. Each frame carries four 24-bit fields, most significant bit first: in-phase and quadrature samples for channel A, then the same pair for channel B. A marker input is high on the first bit of every frame. The block rebuilds each frame and takes the fields of one channel. It then writes 24-bit two's-complement words into a capture memory, using a write strobe and an address.

The phase mode selects the word sequence. The block can write only the in-phase samples or only the quadrature samples, giving one word per frame. It can also write both samples of every frame as an adjacent pair, in either order. In the paired modes the memory depth is shared between the two phases, so each phase gets half the record. A start pulse arms a capture. Writing begins with the first frame whose marker arrives after the pulse. It ends once the memory is full.

Top module: `iq_slot_capture`

## Requirements
- R1: After reset, `wrEn` is 0, `wrAddr` is 0 and `wrData` is 0, and no word is written until a capture is started.
- R2: A frame is 96 bits, and each field arrives most significant bit first. Fields arrive in this order: channel A in-phase, channel A quadrature, channel B in-phase, channel B quadrature. `chanSel` = 0 selects the channel A fields and `chanSel` = 1 selects the channel B fields.
- R3: `phaseMode` = 0 writes one in-phase word per frame, and `phaseMode` = 1 writes one quadrature word per frame.
- R4: `phaseMode` = 2 writes two words per frame, in-phase then quadrature, on consecutive cycles. `phaseMode` = 3 writes the same two words with quadrature first.
- R5: The first word of a frame is written in the cycle after the clock edge that samples the frame's 96th bit. Within a capture, addresses start at 0 and rise by one for each word.
- R6: Before a start pulse, frames are ignored. A frame whose marker arrived before the start pulse, or in the same cycle as it, is not written. A start pulse during a capture has no effect.
- R7: A capture stops after `DEPTH` words (default 32768). In the paired modes this gives `DEPTH`/2 words per phase. Later frames write nothing until the next start pulse, and the next capture begins again at address 0.
- R8: A marker that arrives before 96 bits have been received discards the partial frame and starts counting a new frame at its own bit.
- R9: Bits that arrive after a complete frame and before the next marker are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rstN | input | 1 | Active-low synchronous reset |
| serData | input | 1 | Serial frame data |
| frameStart | input | 1 | High on the first bit of a frame |
| chanSel | input | 1 | Channel select: 0 = A, 1 = B |
| phaseMode | input | 2 | 0 = I only, 1 = Q only, 2 = I then Q, 3 = Q then I |
| start | input | 1 | One-cycle pulse that arms a capture |
| wrEn | output | 1 | Capture memory write strobe |
| wrAddr | output | ADDR_W (15) | Capture memory write address |
| wrData | output | 24 | Captured sample word |

## Verification
Every pairing of channel and phase mode is tested. Each frame carries four distinct field values computed from its index, so taking the wrong field, the wrong channel or the wrong order gives a different word. The streams also contain a frame cut off by an early marker and a long run of bits with no marker. These separate correct frame alignment from a counter that simply wraps every 96 bits. Start pulses are placed in the middle of a frame and in the middle of a capture, and a frame is sent after each capture is full. Together these cover arming, the fixed-length stop and the address restart.

// File: rtl/iq_capture_pkg.sv
package iq_capture_pkg;

  // strobes from the capture control into the datapath
  typedef struct packed {
    logic latch;    // 96th bit is on serData this cycle
    logic emit;     // load a word into wrData
    logic pickQ;    // first word of the frame is the quadrature field
    logic useHold;  // emit the held second word of a pair
  } dpCtl_t;

  localparam int SLOTS = 4;

endpackage

// File: rtl/iq_frame_dp.sv
module iq_frame_dp
  import iq_capture_pkg::*;
#(
  parameter int FIELD_W = 24
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serData,
  input  logic               chanSel,
  input  dpCtl_t             ctl,
  output logic [FIELD_W-1:0] wrData
);

  localparam int FRAME_BITS = SLOTS * FIELD_W;

  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] frameNext;
  logic [FIELD_W-1:0]    slot [SLOTS];
  logic [FIELD_W-1:0]    holdReg;
  logic [1:0]            firstIdx;
  logic [1:0]            secondIdx;

  assign frameNext = {shiftReg[FRAME_BITS-2:0], serData};

  // slot 0 is the first field on the wire
  for (genvar g = 0; g < SLOTS; g++) begin : gSlot
    assign slot[g] = frameNext[FRAME_BITS-1-g*FIELD_W -: FIELD_W];
  end

  assign firstIdx  = {chanSel, ctl.pickQ};
  assign secondIdx = {chanSel, ~ctl.pickQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      holdReg  <= '0;
      wrData   <= '0;
    end else begin
      shiftReg <= frameNext;
      if (ctl.latch) holdReg <= slot[secondIdx];
      if (ctl.emit)  wrData  <= ctl.useHold ? holdReg : slot[firstIdx];
    end
  end

  // second word of a pair follows its frame's first word immediately
  assert_pair_follows_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.useHold |-> $past(ctl.latch && ctl.emit));

  assert_hold_not_clobbered_R4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.useHold |-> !ctl.latch);

endmodule

// File: rtl/iq_capture_ctl.sv
module iq_capture_ctl
  import iq_capture_pkg::*;
#(
  parameter int FIELD_W = 24,
  parameter int DEPTH   = 32768,
  parameter int ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              start,
  input  logic [1:0]        phaseMode,
  output dpCtl_t            ctl,
  output logic              wrEn,
  output logic [ADDR_W-1:0] wrAddr
);

  localparam int FRAME_BITS = SLOTS * FIELD_W;
  localparam int CW         = $clog2(FRAME_BITS);
  localparam logic [CW-1:0]     LAST_BIT  = CW'(FRAME_BITS - 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_ARMED, ST_RUN} capState_t;

  capState_t         state;
  logic [CW-1:0]     bitCnt;
  logic              inFrame;
  logic              frameDone;
  logic              firstEmit;
  logic              secondPend;
  logic              lastWord;
  logic [ADDR_W-1:0] nextAddr;

  // bit alignment: the marker bit is bit 0 of a new frame
  always_ff @(posedge clk) begin
    if (!rstN) begin
      inFrame <= 1'b0;
      bitCnt  <= '0;
    end else if (frameStart) begin
      inFrame <= 1'b1;
      bitCnt  <= CW'(1);
    end else if (inFrame) begin
      if (bitCnt == LAST_BIT) begin
        inFrame <= 1'b0;
        bitCnt  <= '0;
      end else begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

  assign frameDone = inFrame && !frameStart && (bitCnt == LAST_BIT);
  assign firstEmit = frameDone && (state == ST_RUN);
  assign lastWord  = (nextAddr == LAST_ADDR);

  always_comb begin
    ctl.latch   = frameDone;
    ctl.emit    = firstEmit || secondPend;
    ctl.useHold = secondPend;
    ctl.pickQ   = phaseMode[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      nextAddr   <= '0;
      secondPend <= 1'b0;
      wrEn       <= 1'b0;
      wrAddr     <= '0;
    end else begin
      wrEn       <= ctl.emit;
      secondPend <= firstEmit && phaseMode[1] && !lastWord;
      if (ctl.emit) begin
        wrAddr   <= nextAddr;
        nextAddr <= nextAddr + 1'b1;
      end
      case (state)
        ST_IDLE: if (start) begin
          state    <= ST_ARMED;
          nextAddr <= '0;
        end
        ST_ARMED: if (frameStart) state <= ST_RUN;
        ST_RUN:   if (ctl.emit && lastWord) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assert_bitcnt_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_BIT);

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (!wrEn || wrAddr == ADDR_W'($past(wrAddr) + 1'b1)));

  assert_stop_full_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == LAST_ADDR) |=> (!wrEn && state == ST_IDLE));

  assert_no_write_unarmed_R6: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && state != ST_RUN && !secondPend) |=> !wrEn);

endmodule

// File: rtl/iq_slot_capture.sv
module iq_slot_capture
  import iq_capture_pkg::*;
#(
  parameter int FIELD_W = 24,
  parameter int DEPTH   = 32768,
  parameter int ADDR_W  = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serData,
  input  logic               frameStart,
  input  logic               chanSel,
  input  logic [1:0]         phaseMode,
  input  logic               start,
  output logic               wrEn,
  output logic [ADDR_W-1:0]  wrAddr,
  output logic [FIELD_W-1:0] wrData
);

  dpCtl_t ctl;

  iq_capture_ctl #(
    .FIELD_W(FIELD_W),
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .start     (start),
    .phaseMode (phaseMode),
    .ctl       (ctl),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr)
  );

  iq_frame_dp #(
    .FIELD_W(FIELD_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .serData(serData),
    .chanSel(chanSel),
    .ctl    (ctl),
    .wrData (wrData)
  );

endmodule

// File: tb/iq_slot_capture_tb.sv
module iq_slot_capture_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int AW         = 3;
  localparam int FW         = 24;
  localparam int LOGN       = 256;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          serData = 1'b0;
  logic          frameStart = 1'b0;
  logic          chanSel = 1'b0;
  logic [1:0]    phaseMode = 2'd0;
  logic          start = 1'b0;
  logic          wrEn;
  logic [AW-1:0] wrAddr;
  logic [FW-1:0] wrData;

  iq_slot_capture #(.FIELD_W(FW), .DEPTH(DEPTH), .ADDR_W(AW)) u_dut (
    .clk(clk), .rstN(rstN), .serData(serData), .frameStart(frameStart),
    .chanSel(chanSel), .phaseMode(phaseMode), .start(start),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // write monitor, sampled away from the active edge
  logic [FW-1:0] gotWord [LOGN];
  int            gotAddr [LOGN];
  int            gotCyc  [LOGN];
  int            gotN = 0;
  always @(negedge clk) begin
    if (rstN && wrEn && gotN < LOGN) begin
      gotWord[gotN] = wrData;
      gotAddr[gotN] = int'(wrAddr);
      gotCyc[gotN]  = cyc;
      gotN = gotN + 1;
    end
  end

  logic [FW-1:0] expWord [LOGN];
  int            expCyc  [LOGN];
  int            expN;
  int            testCnt = 0;
  int            failCnt = 0;
  bit            finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] fieldVal(input int k, input int f);
    return FW'((k + 1) * 24'h0A3B17) ^ FW'(f * 24'h5C0F01) ^ 24'h800001;
  endfunction

  task automatic sendBit(input logic b, input logic m, input logic s);
    @(negedge clk);
    serData    = b;
    frameStart = m;
    start      = s;
  endtask

  task automatic idleBits(input int n);
    for (int i = 0; i < n; i++) sendBit(logic'(i[0] ^ i[2]), 1'b0, 1'b0);
  endtask

  // len < 96 gives a cut-off frame; startAt is the bit index that carries a start pulse
  task automatic sendFrame(input int k, input int len, input int startAt, input bit expect_);
    logic [4*FW-1:0] fr;
    logic [FW-1:0]   iw;
    logic [FW-1:0]   qw;
    int              endCyc;
    fr = {fieldVal(k, 0), fieldVal(k, 1), fieldVal(k, 2), fieldVal(k, 3)};
    for (int i = 0; i < len; i++)
      sendBit(fr[4*FW-1-i], logic'(i == 0), logic'(i == startAt));
    endCyc = cyc + 1;
    if (expect_ && len == 4*FW) begin
      iw = fieldVal(k, 2*int'(chanSel));
      qw = fieldVal(k, 2*int'(chanSel) + 1);
      if (expN < DEPTH) begin
        expWord[expN] = phaseMode[0] ? qw : iw;
        expCyc[expN]  = endCyc;
        expN++;
      end
      if (phaseMode[1] && expN < DEPTH) begin
        expWord[expN] = phaseMode[0] ? iw : qw;
        expCyc[expN]  = endCyc + 1;
        expN++;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failCnt++;
      $display("FAIL R7: watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  initial begin
    int baseN;
    int cfg;
    int nPer;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(wrEn == 1'b0, "R1", "wrEn after reset", wrEn, 0);
    check(wrAddr == '0, "R1", "wrAddr after reset", wrAddr, 0);
    check(wrData == '0, "R1", "wrData after reset", wrData, 0);

    // R6: frames before any start pulse are not written
    baseN = gotN;
    sendFrame(500, 96, -1, 0);
    idleBits(4);
    check(gotN == baseN, "R6", "writes before start", gotN - baseN, 0);

    for (int c = 0; c < 2; c++) begin
      for (int m = 0; m < 4; m++) begin
        @(negedge clk);
        chanSel   = logic'(c);
        phaseMode = 2'(m);
        cfg   = c * 4 + m;
        baseN = gotN;
        expN  = 0;
        nPer  = (m >= 2) ? 2 : 1;
        if (cfg == 0) sendFrame(100, 96, 40, 0);  // R6: start lands mid-frame, frame dropped
        else          sendBit(1'b0, 1'b0, 1'b1);
        for (int f = 0; f < DEPTH / nPer; f++) begin
          if (f == 1) sendFrame(300 + cfg, 50, -1, 0);  // R8: cut off by next marker
          if (f == 2) idleBits(120);                    // R9: unframed bits
          sendFrame(cfg * 16 + f, 96, (f == 3) ? 10 : -1, 1);  // R6: start mid-capture
        end
        sendFrame(400 + cfg, 96, -1, 1);  // R7: after the store is full
        idleBits(4);
        check(expN == DEPTH, "R7", "expected words per capture", expN, DEPTH);
        check(gotN - baseN == expN, "R7", "words written in capture", gotN - baseN, expN);
        for (int i = 0; i < expN; i++) begin
          check(gotWord[baseN+i] == expWord[i], (m < 2) ? "R2 R3" : "R2 R4",
                $sformatf("word %0d chan %0d mode %0d", i, c, m), gotWord[baseN+i], expWord[i]);
          check(gotAddr[baseN+i] == i, "R5", $sformatf("address of word %0d", i),
                gotAddr[baseN+i], i);
          check(gotCyc[baseN+i] == expCyc[i], (m < 2) ? "R5" : "R4",
                $sformatf("write cycle of word %0d", i), gotCyc[baseN+i], expCyc[i]);
        end
      end
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule